// File: doc/BRIEF.md
# Dual-Modulus NTT Butterfly Unit

This block is the arithmetic core used by a lattice-cryptography accelerator when it runs number-theoretic transforms and pointwise products. Each accepted operation reads two 24-bit lane words `a_i` and `b_i`, a twiddle word `w_i` and two accumulate words `c0_i` and `c1_i`. The block returns two 24-bit result words exactly four clock cycles later. It never stalls, so a new operation can enter on every cycle.

A one-bit mode input sets how the lane words are read. In wide mode each lane holds one coefficient in bits [22:0], and all arithmetic is modulo 8380417. In split mode each lane holds two independent coefficients in bits [11:0] and [23:12], and all arithmetic is modulo 3329. Split mode therefore handles four coefficients per operation, where wide mode handles two.

An opcode selects the operation: a forward butterfly, an inverse butterfly, a plain modular product, or pass-through. After the product has been reduced, an accumulate code can add a memory operand to each result modulo q, or subtract it. This lets a polynomial product be summed in place.

Top module: `dual_mod_bfly`

## Requirements
- R1: `valid_o` equals the value `valid_i` had four rising edges earlier, and the results of that operation appear on `x_o`/`y_o` in the same cycle. An operation may be issued on every cycle.
- R2: With `mode_i`=0, each lane word carries one coefficient in bits [22:0], and arithmetic is modulo 8380417. Input bit 23 is ignored, and output bit 23 is 0.
- R3: With `mode_i`=1, each lane word carries two coefficients in bits [11:0] and [23:12]. Each is computed modulo 3329, with no effect from one on the other.
- R4: `op_i`=0 (forward butterfly) gives x = a + w·b and y = a − w·b.
- R5: `op_i`=1 (inverse butterfly) gives x = a + b and y = (a − b)·w.
- R6: `op_i`=2 (product) gives x = b·w and y = a.
- R7: `op_i`=3 (pass-through) gives x = a and y = b.
- R8: `acc_i`=1 adds `c0_i` to x and `c1_i` to y after the operation, modulo q. `acc_i`=2 subtracts them. `acc_i`=0 and 3 leave the results unchanged.
- R9: For inputs already in [0, q−1], every output coefficient lies in [0, q−1], including the operand values 0 and q−1.
- R10: While `rst_ni` is low, `valid_o` and the result words are 0. `valid_o` stays 0 until four edges after the first accepted operation.
- R11: Operations issued on consecutive cycles may use different modes, opcodes and accumulate codes, and each returns its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issued this cycle |
| mode_i | input | 1 | 0: one coefficient mod 8380417 per lane; 1: two coefficients mod 3329 per lane |
| op_i | input | 2 | 0 forward, 1 inverse, 2 product, 3 pass-through |
| acc_i | input | 2 | 0 none, 1 add, 2 subtract, 3 none |
| a_i | input | 24 | First lane word |
| b_i | input | 24 | Second lane word |
| w_i | input | 24 | Twiddle word (one factor, or two in split mode) |
| c0_i | input | 24 | Accumulate operand for x |
| c1_i | input | 24 | Accumulate operand for y |
| valid_o | output | 1 | Result valid |
| x_o | output | 24 | First result word |
| y_o | output | 24 | Second result word |

## Verification
A fixed table issues every opcode in both modes, with modes alternating from one cycle to the next. This separates errors in the lane split from errors in the per-opcode routing, and it shows whether the mode travels with its operation. Directed words with 0 and q−1 in every sub-lane check three things: that the products of −1 by −1 reduce to 1, that subtraction wraps to q−1, and that the two 12-bit sub-lanes do not disturb each other. A word with bit 23 set in wide mode shows that the unused bit is ignored. A long random stream, in which extreme values are frequent, is compared against a behavioural model that uses plain division. This exposes reduction errors that appear only for large products.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
  typedef enum logic [1:0] {
    OP_CT   = 2'd0,
    OP_GS   = 2'd1,
    OP_PWM  = 2'd2,
    OP_PASS = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2,
    ACC_RSV  = 2'd3
  } acc_e;

  localparam int unsigned WIDE_W   = 23;
  localparam int unsigned WIDE_Q   = 8380417;
  localparam int unsigned NARROW_W = 12;
  localparam int unsigned NARROW_Q = 3329;
  localparam int unsigned PIPE_LAT = 4;
endpackage

// File: rtl/dmb_barrett.sv
// Barrett reduction of a product x < Q^2 into [0, Q-1]
module dmb_barrett #(
  parameter int unsigned W = 23,
  parameter int unsigned Q = 8380417
) (
  input  logic [2*W-1:0] x_i,
  output logic [W-1:0]   r_o
);
  localparam int unsigned    K  = 2 * W;
  localparam longint unsigned MU = (64'd1 << K) / Q;
  localparam int unsigned    MW = W + 2;
  localparam int unsigned    PW = 2 * W + MW;
  localparam logic [W+1:0]   QX = (W + 2)'(Q);

  logic [PW-1:0] t, qq;
  logic [MW-1:0] qh;
  logic [W+1:0]  r0, r1, r2;

  always_comb begin
    t  = PW'(x_i) * PW'(MU);
    qh = t[PW-1:K];
    qq = PW'(qh) * PW'(Q);
    // estimate error is at most 2Q
    r0 = x_i[W+1:0] - qq[W+1:0];
    r1 = (r0 >= QX) ? r0 - QX : r0;
    r2 = (r1 >= QX) ? r1 - QX : r1;
    r_o = r2[W-1:0];
  end
endmodule

// File: rtl/dmb_core.sv
// Four-stage butterfly for one modulus
module dmb_core
  import dmb_pkg::*;
#(
  parameter int unsigned W = 23,
  parameter int unsigned Q = 8380417
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  op_e          op_i,
  input  acc_e         acc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] w_i,
  input  logic [W-1:0] c0_i,
  input  logic [W-1:0] c1_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  localparam logic [W:0] QX = (W + 1)'(Q);

  typedef struct packed {
    op_e          op;
    acc_e         acc;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] sum;
    logic [W-1:0] c0;
    logic [W-1:0] c1;
  } side_t;

  function automatic logic [W-1:0] add_q(logic [W-1:0] p, logic [W-1:0] r);
    logic [W:0] s;
    s = {1'b0, p} + {1'b0, r};
    if (s >= QX) s = s - QX;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] sub_q(logic [W-1:0] p, logic [W-1:0] r);
    logic [W:0] d;
    d = {1'b0, p} - {1'b0, r};
    if (p < r) d = d + QX;
    return d[W-1:0];
  endfunction

  logic           e1, e2, e3;
  side_t          s1_sd, s2_sd, s3_sd;
  logic [W-1:0]   s1_m, s1_w;
  logic [2*W-1:0] s2_prod;
  logic [W-1:0]   s3_p;
  logic [W-1:0]   red_p;
  logic [W-1:0]   xr, yr, xn, yn;

  // stage 1: pre-add/sub, pick multiplicand
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1    <= 1'b0;
      s1_sd <= '0;
      s1_m  <= '0;
      s1_w  <= '0;
    end else begin
      e1 <= en_i;
      if (en_i) begin
        s1_sd.op  <= op_i;
        s1_sd.acc <= acc_i;
        s1_sd.a   <= a_i;
        s1_sd.b   <= b_i;
        s1_sd.sum <= add_q(a_i, b_i);
        s1_sd.c0  <= c0_i;
        s1_sd.c1  <= c1_i;
        s1_m      <= (op_i == OP_GS) ? sub_q(a_i, b_i) : b_i;
        s1_w      <= w_i;
      end
    end
  end

  // stage 2: raw product
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e2      <= 1'b0;
      s2_sd   <= '0;
      s2_prod <= '0;
    end else begin
      e2 <= e1;
      if (e1) begin
        s2_sd   <= s1_sd;
        s2_prod <= (2 * W)'(s1_m) * (2 * W)'(s1_w);
      end
    end
  end

  dmb_barrett #(.W(W), .Q(Q)) u_red (
    .x_i (s2_prod),
    .r_o (red_p)
  );

  // stage 3: reduced product
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e3    <= 1'b0;
      s3_sd <= '0;
      s3_p  <= '0;
    end else begin
      e3 <= e2;
      if (e2) begin
        s3_sd <= s2_sd;
        s3_p  <= red_p;
      end
    end
  end

  // stage 4: combine, then optional accumulate
  always_comb begin
    unique case (s3_sd.op)
      OP_CT:   begin xr = add_q(s3_sd.a, s3_p); yr = sub_q(s3_sd.a, s3_p); end
      OP_GS:   begin xr = s3_sd.sum;            yr = s3_p;                 end
      OP_PWM:  begin xr = s3_p;                 yr = s3_sd.a;              end
      default: begin xr = s3_sd.a;              yr = s3_sd.b;              end
    endcase
    unique case (s3_sd.acc)
      ACC_ADD: begin xn = add_q(xr, s3_sd.c0); yn = add_q(yr, s3_sd.c1); end
      ACC_SUB: begin xn = sub_q(xr, s3_sd.c0); yn = sub_q(yr, s3_sd.c1); end
      default: begin xn = xr;                  yn = yr;                  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (e3) begin
      x_o <= xn;
      y_o <= yn;
    end
  end
endmodule

// File: rtl/dual_mod_bfly.sv
module dual_mod_bfly
  import dmb_pkg::*;
#(
  parameter int unsigned W_WIDE   = WIDE_W,
  parameter int unsigned Q_WIDE   = WIDE_Q,
  parameter int unsigned W_NARROW = NARROW_W,
  parameter int unsigned Q_NARROW = NARROW_Q
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    mode_i,
  input  logic [1:0]              op_i,
  input  logic [1:0]              acc_i,
  input  logic [2*W_NARROW-1:0]   a_i,
  input  logic [2*W_NARROW-1:0]   b_i,
  input  logic [2*W_NARROW-1:0]   w_i,
  input  logic [2*W_NARROW-1:0]   c0_i,
  input  logic [2*W_NARROW-1:0]   c1_i,
  output logic                    valid_o,
  output logic [2*W_NARROW-1:0]   x_o,
  output logic [2*W_NARROW-1:0]   y_o
);
  localparam int unsigned NSUB   = 2;
  localparam int unsigned LANE_W = NSUB * W_NARROW;
  localparam int unsigned LAT    = PIPE_LAT;

  logic [LAT-1:0] vld_q, mode_q;
  logic           en_wide, en_split;
  logic [W_WIDE-1:0]                 wide_x, wide_y;
  logic [NSUB-1:0][W_NARROW-1:0]     sub_x, sub_y;

  assign en_wide  = valid_i & ~mode_i;
  assign en_split = valid_i & mode_i;

  dmb_core #(.W(W_WIDE), .Q(Q_WIDE)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_wide),
    .op_i   (op_e'(op_i)),
    .acc_i  (acc_e'(acc_i)),
    .a_i    (a_i[W_WIDE-1:0]),
    .b_i    (b_i[W_WIDE-1:0]),
    .w_i    (w_i[W_WIDE-1:0]),
    .c0_i   (c0_i[W_WIDE-1:0]),
    .c1_i   (c1_i[W_WIDE-1:0]),
    .x_o    (wide_x),
    .y_o    (wide_y)
  );

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    dmb_core #(.W(W_NARROW), .Q(Q_NARROW)) u_sub (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_split),
      .op_i   (op_e'(op_i)),
      .acc_i  (acc_e'(acc_i)),
      .a_i    (a_i[g*W_NARROW +: W_NARROW]),
      .b_i    (b_i[g*W_NARROW +: W_NARROW]),
      .w_i    (w_i[g*W_NARROW +: W_NARROW]),
      .c0_i   (c0_i[g*W_NARROW +: W_NARROW]),
      .c1_i   (c1_i[g*W_NARROW +: W_NARROW]),
      .x_o    (sub_x[g]),
      .y_o    (sub_y[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      mode_q <= '0;
    end else begin
      vld_q  <= {vld_q[LAT-2:0], valid_i};
      mode_q <= {mode_q[LAT-2:0], mode_i};
    end
  end

  assign valid_o = vld_q[LAT-1];
  assign x_o = mode_q[LAT-1] ? sub_x : LANE_W'(wide_x);
  assign y_o = mode_q[LAT-1] ? sub_y : LANE_W'(wide_y);
endmodule

// File: rtl/dmb_checker.sv
module dmb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        mode_i,
  input logic [1:0]  op_i,
  input logic [1:0]  acc_i,
  input logic [23:0] a_i,
  input logic [23:0] b_i,
  input logic [23:0] w_i,
  input logic [23:0] c0_i,
  input logic [23:0] c1_i,
  input logic        valid_o,
  input logic [23:0] x_o,
  input logic [23:0] y_o
);
  logic [2:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3'd4) |-> (valid_o == $past(valid_i, 4))); // R1

  AST_WIDE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3'd4 && valid_o && !$past(mode_i, 4)) |->
      (x_o < 24'd8380417 && y_o < 24'd8380417)); // R2

  AST_SPLIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3'd4 && valid_o && $past(mode_i, 4)) |->
      (x_o[11:0] < 12'd3329 && x_o[23:12] < 12'd3329 &&
       y_o[11:0] < 12'd3329 && y_o[23:12] < 12'd3329)); // R9

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3'd4 && valid_o && $past(mode_i, 4) &&
     $past(op_i, 4) == 2'd3 && $past(acc_i, 4) == 2'd0) |->
      (x_o == $past(a_i, 4) && y_o == $past(b_i, 4))); // R7

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age < 3'd4) |-> !valid_o); // R10
endmodule

bind dual_mod_bfly dmb_checker u_chk (.*);

// File: tb/dual_mod_bfly_test.sv
`timescale 1ns/1ps
module dual_mod_bfly_test;
  localparam longint QW = 8380417;
  localparam longint QN = 3329;

  typedef struct packed {
    logic        md;
    logic [1:0]  op;
    logic [1:0]  acc;
    logic [23:0] a, b, w, c0, c1;
  } stim_t;

  // modes alternate row to row (R11)
  localparam stim_t TAB [12] = '{
    '{1'b0, 2'd0, 2'd0, 24'd1,       24'd2,       24'd3,       24'd0,       24'd0},
    '{1'b1, 2'd0, 2'd0, 24'h123456,  24'h0A0B0C,  24'h7FF001,  24'd0,       24'd0},
    '{1'b0, 2'd1, 2'd0, 24'd5000000, 24'd8000000, 24'd12345,   24'd0,       24'd0},
    '{1'b1, 2'd1, 2'd0, 24'hCFF001,  24'h002CFF,  24'h100100,  24'd0,       24'd0},
    '{1'b0, 2'd2, 2'd0, 24'd7,       24'd8380416, 24'd4190000, 24'd0,       24'd0},
    '{1'b1, 2'd2, 2'd0, 24'h000000,  24'hD00D00,  24'h0020FF,  24'd0,       24'd0},
    '{1'b0, 2'd3, 2'd0, 24'd8380416, 24'd0,       24'd9,       24'd0,       24'd0},
    '{1'b1, 2'd3, 2'd0, 24'hABC123,  24'h0010CF,  24'h000000,  24'd0,       24'd0},
    '{1'b0, 2'd0, 2'd1, 24'd100,     24'd200,     24'd300,     24'd8380416, 24'd1},
    '{1'b1, 2'd0, 2'd2, 24'h00A00B,  24'h00C00D,  24'h002003,  24'hD00D00,  24'h001001},
    '{1'b0, 2'd1, 2'd3, 24'd11,      24'd22,      24'd33,      24'd5,       24'd6},
    '{1'b1, 2'd2, 2'd1, 24'h321654,  24'h111222,  24'h0AB0CD,  24'h123123,  24'h456456}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [1:0]  acc_i = '0;
  logic [23:0] a_i = '0, b_i = '0, w_i = '0, c0_i = '0, c1_i = '0;
  logic        valid_o;
  logic [23:0] x_o, y_o;

  int total = 0;
  int bad = 0;

  bit          pv [4];
  logic [23:0] px [4];
  logic [23:0] py [4];
  string       pt [4];

  always #10 clk_i = ~clk_i;

  dual_mod_bfly uut (.*);

  function automatic logic [63:0] one(longint q, int op, int acc,
                                      longint a, longint b, longint w,
                                      longint c0, longint c1);
    longint x, y, p;
    case (op)
      0: begin p = (w * b) % q; x = (a + p) % q; y = (a - p + q) % q; end
      1: begin x = (a + b) % q; y = (((a - b + q) % q) * w) % q; end
      2: begin x = (b * w) % q; y = a; end
      default: begin x = a; y = b; end
    endcase
    if (acc == 1) begin x = (x + c0) % q; y = (y + c1) % q; end
    else if (acc == 2) begin x = (x - c0 + q) % q; y = (y - c1 + q) % q; end
    return {32'(x), 32'(y)};
  endfunction

  function automatic logic [47:0] model(stim_t s);
    logic [63:0] r0, r1;
    if (!s.md) begin
      r0 = one(QW, int'(s.op), int'(s.acc), longint'(s.a[22:0]), longint'(s.b[22:0]),
               longint'(s.w[22:0]), longint'(s.c0[22:0]), longint'(s.c1[22:0]));
      return {24'(r0[63:32]), 24'(r0[31:0])};
    end
    r0 = one(QN, int'(s.op), int'(s.acc), longint'(s.a[11:0]), longint'(s.b[11:0]),
             longint'(s.w[11:0]), longint'(s.c0[11:0]), longint'(s.c1[11:0]));
    r1 = one(QN, int'(s.op), int'(s.acc), longint'(s.a[23:12]), longint'(s.b[23:12]),
             longint'(s.w[23:12]), longint'(s.c0[23:12]), longint'(s.c1[23:12]));
    return {12'(r1[63:32]), 12'(r0[63:32]), 12'(r1[31:0]), 12'(r0[31:0])};
  endfunction

  function automatic string tag_of(stim_t s);
    string t;
    case (s.op)
      2'd0: t = "R4";
      2'd1: t = "R5";
      2'd2: t = "R6";
      default: t = "R7";
    endcase
    if (s.acc != 2'd0) t = {t, "/R8"};
    return {t, s.md ? "/R3" : "/R2", "/R11"};
  endfunction

  function automatic logic [23:0] rv(logic md);
    int k;
    k = int'($urandom % 6);
    if (!md) begin
      if (k == 0) return 24'd0;
      if (k == 1) return 24'(QW - 1);
      return 24'($urandom % QW);
    end
    if (k == 0) return 24'd0;
    if (k == 1) return {12'(QN - 1), 12'(QN - 1)};
    return {12'($urandom % QN), 12'($urandom % QN)};
  endfunction

  // one cycle: check what left the pipe, then issue
  task automatic cycle(input bit v, input stim_t s, input bit hand,
                       input logic [23:0] hx, input logic [23:0] hy, input string tag);
    logic [47:0] e;
    @(negedge clk_i);
    total++;
    if (valid_o !== pv[3]) begin
      bad++;
      $display("FAIL R1 valid_o actual=%b expected=%b", valid_o, pv[3]);
    end
    if (pv[3]) begin
      total++;
      if (x_o !== px[3]) begin
        bad++;
        $display("FAIL %s x_o actual=%h expected=%h", pt[3], x_o, px[3]);
      end
      total++;
      if (y_o !== py[3]) begin
        bad++;
        $display("FAIL %s y_o actual=%h expected=%h", pt[3], y_o, py[3]);
      end
    end
    for (int i = 3; i > 0; i--) begin
      pv[i] = pv[i-1]; px[i] = px[i-1]; py[i] = py[i-1]; pt[i] = pt[i-1];
    end
    e = model(s);
    pv[0] = v;
    px[0] = hand ? hx : e[47:24];
    py[0] = hand ? hy : e[23:0];
    pt[0] = tag;
    valid_i = v; mode_i = s.md; op_i = s.op; acc_i = s.acc;
    a_i = s.a; b_i = s.b; w_i = s.w; c0_i = s.c0; c1_i = s.c1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, '0, '0, "R1");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    stim_t s;
    for (int i = 0; i < 4; i++) begin pv[i] = 1'b0; px[i] = '0; py[i] = '0; pt[i] = ""; end

    // reset state (R10)
    repeat (3) @(negedge clk_i);
    total++;
    if (valid_o !== 1'b0 || x_o !== 24'd0 || y_o !== 24'd0) begin
      bad++;
      $display("FAIL R10 reset actual=%b/%h/%h expected=0/0/0", valid_o, x_o, y_o);
    end
    rst_ni = 1'b1;
    idle(5);

    // table walk, back-to-back issue
    foreach (TAB[i]) cycle(1'b1, TAB[i], 1'b0, '0, '0, tag_of(TAB[i]));
    idle(5);

    // corner cases with hand-derived results
    cycle(1'b1, '{1'b0, 2'd0, 2'd0, 24'd0, 24'd8380416, 24'd8380416, 24'd0, 24'd0},
          1'b1, 24'd1, 24'd8380416, "R9");
    cycle(1'b1, '{1'b1, 2'd0, 2'd0, 24'd0, 24'hD00D00, 24'hD00D00, 24'd0, 24'd0},
          1'b1, 24'h001001, 24'hD00D00, "R3");
    cycle(1'b1, '{1'b0, 2'd3, 2'd0, 24'h800005, 24'h800000, 24'd0, 24'd0, 24'd0},
          1'b1, 24'd5, 24'd0, "R2");
    cycle(1'b1, '{1'b0, 2'd3, 2'd2, 24'd0, 24'd0, 24'd0, 24'd1, 24'd0},
          1'b1, 24'd8380416, 24'd0, "R8");
    cycle(1'b1, '{1'b1, 2'd1, 2'd0, 24'h000D00, 24'h000D00, 24'h001002, 24'd0, 24'd0},
          1'b1, 24'h000CFF, 24'h000000, "R5");
    cycle(1'b1, '{1'b1, 2'd3, 2'd3, 24'h001002, 24'h003004, 24'd0, 24'h005005, 24'h005005},
          1'b1, 24'h001002, 24'h003004, "R8");
    idle(5);

    // random stream, extremes frequent
    for (int i = 0; i < 400; i++) begin
      s.md  = logic'($urandom % 2);
      s.op  = 2'($urandom % 4);
      s.acc = 2'($urandom % 4);
      s.a = rv(s.md); s.b = rv(s.md); s.w = rv(s.md);
      s.c0 = rv(s.md); s.c1 = rv(s.md);
      cycle(logic'($urandom % 8 != 0), s, 1'b0, '0, '0, "R9");
    end
    idle(6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule